// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is a target-only SMBus device that answers on one fixed 7-bit address and gives a bus controller access to a small file of byte-wide control registers. Every register is also driven out in parallel, so that the logic around the block can use the values directly. The bus pins are sampled as inputs. SDA is driven only as an open-drain pull-low enable. All logic runs on a system clock that is much faster than SCL.

There are two transaction types.

- **Indexed block write.** The controller sends the address byte with R/W low, then a starting register offset, then a nonzero byte count, then that many data bytes. The data bytes land in consecutive registers.
- **Indexed block read.** The controller sends the write address byte and the offset, then issues a repeated START and the read address byte. The target first returns a count of the registers that remain from the offset to the end of the file. It then returns register contents, starting at the offset. The read ends when the controller NACKs a byte and then sends STOP.

Top module: `smbus_regblk`

## Requirements
- R1: The block acknowledges only address byte 0xD2 (write) or 0xD3 (read), that is 7-bit address 0x69. Any other address byte is NACKed, and the rest of that transaction leaves the registers unchanged and SDA undriven.
- R2: In a write, the offset byte, the count byte and each data byte are ACKed. Data byte k is stored in register offset+k.
- R3: A write count byte of 0x00 is NACKed. No register changes for the rest of that transaction.
- R4: An offset byte not below NUM_REGS (4 by default) is NACKed, and the rest of that transaction is ignored.
- R5: A data byte beyond the announced count, or one aimed at a register at or above NUM_REGS, is NACKed and discarded. Every later byte of that transaction is ignored.
- R6: After the read address byte, the target sends NUM_REGS minus the offset as the count byte. It then sends register contents starting at the offset stored during the write phase, or at the position where the last accepted write data left the index.
- R7: A read data byte past the last register is 0x00. SDA is released during every ACK/NACK bit that the controller drives. A controller NACK ends the read.
- R8: A STOP or START returns the target to idle at any point. Data bytes already ACKed in an unfinished write stay stored.
- R9: After reset, register 0 holds 0x35 and the other registers hold 0x00. Register k appears on regs_o[8k+7:8k]. Within register 0, bit 7 is spread select, bit 6 is the output-enable control source, bit 5 is the software power-down enable, bits 4:1 are the frequency-margin code and bit 0 is an output enable.
- R10: sda_oe_o changes only while SCL is low. The ACK pull-low starts after the eighth SCL fall of a byte and ends after the ninth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level (wired) |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| regs_o | output | NUM_REGS*8 | All registers, register k at bits 8k+7:8k |

## Verification
The assertions assume the following about the bus:
- SCL stays high and stays low for several system clocks, so every edge passes the two-flop synchronizer before the next edge arrives.
- The controller changes SDA only while SCL is low, except when it forms a START or a STOP.
- The controller never issues a START while the target is pulling SDA low.

The bench master keeps to these rules. Each SCL phase lasts eight system clocks. Data is set up in the middle of each low phase. Repeated STARTs are formed only after the target has released SDA. SDA is modelled as the wired AND of the master's drive and the target's pull-low.

// File: rtl/smbrb_pkg.sv
package smbrb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_MACK
  } state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_OFFS,
    PH_CNT,
    PH_DATA
  } phase_e;
endpackage

// File: rtl/smbrb_line_mon.sv
module smbrb_line_mon #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_p  <= scl_ff[STAGES-1];
      sda_p  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
  // SDA edge while SCL held high
  assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/smbrb_regfile.sv
module smbrb_regfile #(
  parameter int NUM_REGS = 4,
  parameter logic [NUM_REGS*8-1:0] RST_VALS = '0,
  localparam int AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [AW-1:0]         waddr_i,
  input  logic [7:0]            wdata_i,
  input  logic [AW-1:0]         raddr_i,
  output logic [7:0]            rdata_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic [7:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              regs_q[g] <= RST_VALS[8*g +: 8];
      else if (we_i && waddr_i == AW'(g))       regs_q[g] <= wdata_i;
    end
    assign regs_o[8*g +: 8] = regs_q[g];
  end

  assign rdata_o = regs_q[raddr_i];
endmodule

// File: rtl/smbus_regblk.sv
module smbus_regblk
  import smbrb_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [NUM_REGS*8-1:0] RST_VALS = (NUM_REGS*8)'('h35),
  localparam int AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  smbrb_line_mon #(.STAGES(2)) u_mon (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  state_e     state_q;
  phase_e     phase_q;
  logic [3:0] cnt_q;
  logic [7:0] shreg_q, ptr_q, left_q;
  logic       oe_q, rd_q, mack_q;

  logic       in_range, ack_ok, we;
  logic [7:0] rdata, rd_byte, cnt_byte, ptr_inc;

  smbrb_regfile #(.NUM_REGS(NUM_REGS), .RST_VALS(RST_VALS)) u_rf (
    .clk_i, .rst_ni,
    .we_i(we), .waddr_i(ptr_q[AW-1:0]), .wdata_i(shreg_q),
    .raddr_i(ptr_q[AW-1:0]), .rdata_o(rdata), .regs_o(regs_o)
  );

  always_comb begin
    in_range = ptr_q < 8'(NUM_REGS);
    rd_byte  = in_range ? rdata : 8'h00;
    cnt_byte = in_range ? 8'(NUM_REGS) - ptr_q : 8'h00;
    ptr_inc  = (ptr_q != 8'hFF) ? ptr_q + 8'd1 : ptr_q;
    unique case (phase_q)
      PH_ADDR: ack_ok = shreg_q[7:1] == DEV_ADDR;
      PH_OFFS: ack_ok = shreg_q < 8'(NUM_REGS);
      PH_CNT:  ack_ok = shreg_q != 8'h00;
      default: ack_ok = (left_q != 8'h00) && in_range;
    endcase
    we = (state_q == ST_RX) && scl_fall && (cnt_q == 4'd8) &&
         (phase_q == PH_DATA) && ack_ok;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= PH_ADDR;
      cnt_q   <= '0;
      shreg_q <= '0;
      ptr_q   <= '0;
      left_q  <= '0;
      oe_q    <= 1'b0;
      rd_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else if (start_det) begin
      state_q <= ST_RX;
      phase_q <= PH_ADDR;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise) begin
            shreg_q <= {shreg_q[6:0], sda_s};
            cnt_q   <= cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (ack_ok) begin
              oe_q    <= 1'b1;
              state_q <= ST_RACK;
              unique case (phase_q)
                PH_ADDR: begin rd_q <= shreg_q[0]; phase_q <= PH_OFFS; end
                PH_OFFS: begin ptr_q <= shreg_q;  phase_q <= PH_CNT;  end
                PH_CNT:  begin left_q <= shreg_q; phase_q <= PH_DATA; end
                default: begin ptr_q <= ptr_inc;  left_q <= left_q - 8'd1; end
              endcase
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_RACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            if (rd_q) begin
              state_q <= ST_TX;
              shreg_q <= cnt_byte;
              oe_q    <= ~cnt_byte[7];
            end else begin
              state_q <= ST_RX;
              oe_q    <= 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              oe_q    <= 1'b0;
              state_q <= ST_MACK;
              cnt_q   <= '0;
            end else begin
              cnt_q   <= cnt_q + 4'd1;
              shreg_q <= {shreg_q[6:0], 1'b0};
              oe_q    <= ~shreg_q[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) mack_q <= ~sda_s;
          else if (scl_fall) begin
            if (mack_q) begin
              shreg_q <= rd_byte;
              oe_q    <= ~rd_byte[7];
              ptr_q   <= ptr_inc;
              state_q <= ST_TX;
              cnt_q   <= '0;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/smbrb_chk.sv
module smbrb_chk #(
  parameter int W = 32,
  parameter logic [7:0] RST0 = 8'h35
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         scl_s,
  input logic         scl_fall,
  input logic         stop_det,
  input logic [2:0]   state_i,
  input logic         sda_oe_o,
  input logic [W-1:0] regs_o
);
  assert_oe_rise_scl_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !$past(scl_s));

  assert_release_after_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);

  assert_free_sda_mack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 3'(smbrb_pkg::ST_MACK)) |-> !sda_oe_o);

  assert_write_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regs_o) |-> $past(scl_fall));

  assert_reset_value_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> regs_o[7:0] == RST0);
endmodule

bind smbus_regblk smbrb_chk #(.W(NUM_REGS*8), .RST0(RST_VALS[7:0])) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .scl_fall(scl_fall),
  .stop_det(stop_det), .state_i(state_q), .sda_oe_o(sda_oe_o), .regs_o(regs_o)
);

// File: tb/smbus_regblk_test.sv
module smbus_regblk_test;
  localparam int N = 4;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [N*8-1:0] regs;
  wire sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  smbus_regblk uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .regs_o(regs)
  );

  int tests = 0, fails = 0, cyc = 0, p = 0;
  logic [7:0] exp_r [N];
  logic [7:0] wq[$];
  logic cmp_en = 1'b0, oe_prev = 1'b0;

  task automatic check(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [N*8-1:0] packed_exp();
    logic [N*8-1:0] v;
    for (int k = 0; k < N; k++) v[8*k +: 8] = exp_r[k];
    return v;
  endfunction

  // per-clock model comparison
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (sda_oe !== oe_prev) check("R10", "sda_oe moved while SCL high", int'(scl_m), 0);
      oe_prev = sda_oe;
      if (cmp_en) check("R9", "register file vs model", int'(regs == packed_exp()), 1);
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H); scl_m = 1'b1; tick(H); sda_m = 1'b1; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(H); scl_m = 1'b1; tick(H); scl_m = 1'b0;
    end
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H/2);
    ack = !sda_line; tick(H/2); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H); scl_m = 1'b1; tick(H/2); b[i] = sda_line; tick(H/2); scl_m = 1'b0;
    end
    sda_m = !ack; tick(4);
    check("R7", "SDA released in master ack bit", int'(sda_oe), 0);
    tick(H-4); scl_m = 1'b1; tick(H); scl_m = 1'b0; sda_m = 1'b1;
  endtask

  // write with queued data in wq; expected ACKs follow the requirements
  task automatic do_write(input logic [7:0] ab, input logic [7:0] off, input logic [7:0] cnt,
                          input bit end_stop, input string req);
    bit ack, alive, e;
    int left;
    cmp_en = 1'b0;
    bus_start();
    e = (ab[7:1] == 7'h69) && !ab[0];
    send_byte(ab, ack); check(req, "address ack", int'(ack), int'(e)); alive = e;
    e = alive && (off < N);
    send_byte(off, ack); check(req, "offset ack", int'(ack), int'(e)); alive = e;
    if (e) p = off;
    e = alive && (cnt != 0);
    send_byte(cnt, ack); check(req, "count ack", int'(ack), int'(e)); alive = e;
    left = cnt;
    foreach (wq[k]) begin
      e = alive && (left > 0) && (p < N);
      send_byte(wq[k], ack); check(req, "data ack", int'(ack), int'(e)); alive = e;
      if (e) begin exp_r[p] = wq[k]; p++; left--; end
    end
    if (end_stop) begin bus_stop(); cmp_en = 1'b1; end
  endtask

  task automatic read_tail(input int nb, input string req);
    bit ack;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD3, ack); check(req, "read address ack", int'(ack), 1);
    recv_byte(1'b1, b); check(req, "count byte", int'(b), (p < N) ? N - p : 0);
    for (int k = 0; k < nb; k++) begin
      recv_byte(k < nb - 1, b);
      check(req, "read data", int'(b), (p < N) ? int'(exp_r[p]) : 0);
      if (p < 255) p++;
    end
    bus_stop(); cmp_en = 1'b1;
  endtask

  task automatic do_read(input logic [7:0] off, input int nb, input string req);
    bit ack;
    cmp_en = 1'b0;
    bus_start();
    send_byte(8'hD2, ack); check(req, "address ack", int'(ack), 1);
    send_byte(off, ack); check(req, "offset ack", int'(ack), 1);
    p = off;
    read_tail(nb, req);
  endtask

  initial begin
    exp_r[0] = 8'h35;
    for (int k = 1; k < N; k++) exp_r[k] = 8'h00;
    tick(4); rst_n = 1'b1; tick(4);
    // R9 reset state
    check("R9", "reset register image", int'(regs == packed_exp()), 1);
    check("R9", "reg0 reset value", int'(regs[7:0]), 8'h35);
    check("R9", "no SDA drive after reset", int'(sda_oe), 0);
    cmp_en = 1'b1;

    wq = {8'hAA, 8'h55, 8'h0F, 8'hF0};
    do_write(8'hD2, 8'd0, 8'd4, 1'b1, "R2");        // R2 full write
    do_read(8'd0, 4, "R6");                           // R6 read from 0
    do_read(8'd2, 3, "R7");                           // R7 read past end
    do_write(8'hA4, 8'd1, 8'd1, 1'b1, "R1");         // R1 foreign address
    wq = {8'h12};
    do_write(8'hD0, 8'd0, 8'd1, 1'b1, "R1");
    do_write(8'hD2, 8'd1, 8'd0, 1'b1, "R3");         // R3 zero count
    do_write(8'hD2, 8'd4, 8'd1, 1'b1, "R4");         // R4 offset out of range
    wq = {8'h11, 8'h22};
    do_write(8'hD2, 8'd1, 8'd1, 1'b1, "R5");         // R5 beyond count
    wq = {8'h33, 8'h44};
    do_write(8'hD2, 8'd3, 8'd2, 1'b1, "R5");         // R5 past last register
    wq = {8'h77};
    do_write(8'hD2, 8'd0, 8'd3, 1'b1, "R8");         // R8 STOP mid-write keeps byte
    check("R8", "acked byte kept after STOP", int'(regs[7:0]), 8'h77);
    wq = {8'h99};
    do_write(8'hD2, 8'd2, 8'd2, 1'b0, "R8");         // R8 START mid-write
    read_tail(2, "R6");                               // index continues after write
    check("R8", "acked byte kept after START", int'(regs[23:16]), 8'h99);
    do_read(8'd1, 1, "R6");
    tick(20);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule